// File: doc/BRIEF.md
# Presettable Register File

This block is a small register file whose words live in an inferred RAM that has no reset of its own. To software it still looks as though it resets. A few low addresses are marked as preset entries. Each preset entry has a one-bit "written since reset" marker kept in flip-flops. A synchronous reset clears every marker, and any write to a preset entry sets its marker.

The block has one write port and two independent read ports, all on a single clock. Each read is registered. At the same edge that captures the RAM word, the read path also captures whether the address is a preset entry whose marker is still clear. When it is, the port drives that entry's fixed preset value in place of the RAM word.

Addresses outside the preset set return whatever the RAM holds, and reset does not touch them. Because the RAM is read before it is written, a read and a write to the same address at the same edge return the old contents. For a preset entry that has not yet been written, the old contents are its preset value.

Top module: `rfp_regfile`

## Requirements
- R1: The file holds DEPTH=20 words of 32 bits, addressed by 5 bits. A write with wr_en high and rst low at a rising edge stores wr_data at wr_addr, and a later read of that address returns it.
- R2: Each read port has one cycle of latency. rdN_data shows the word for the address sampled at the previous rising edge and does not follow a change of rdN_addr until the next edge.
- R3: From the first cycle after reset until written, addresses 0, 1 and 2 read 0xC0DE0001, 0xC0DE0002 and 0xC0DE0003 respectively.
- R4: After a write to a preset address, reads of it return the written data, and its marker stays set until the next reset.
- R5: A later reset makes addresses 0, 1 and 2 read their preset values again, even after they were written. This includes a read whose address is sampled during the reset.
- R6: Reset does not alter addresses 3 to 19. A word written there before a reset reads back unchanged after it.
- R7: When a read and a write hit the same address at the same edge, the read returns the value held before that write. For an unwritten preset entry, that value is its preset value. The next read returns the new data.
- R8: A write presented while rst is high stores nothing and sets no marker.
- R9: The two read ports work independently. Each can read a different address in the same cycle and get that address's own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all ports |
| rst | input | 1 | Synchronous reset, active high; clears the written markers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd0_addr | input | 5 | Read port 0 address |
| rd0_data | output | 32 | Read port 0 data, one cycle after its address |
| rd1_addr | input | 5 | Read port 1 address |
| rd1_data | output | 32 | Read port 1 data, one cycle after its address |

## Verification
A write takes effect at the rising edge where wr_en is sampled. A read address sampled at an edge produces its data right after that same edge, so a read set up in the cycle after a write already sees the new word. The bench changes inputs only on falling edges and compares outputs on the following falling edge, which is one register stage after the capturing rising edge. For the latency check, it also compares one time unit after changing the address, to confirm that the output has not moved yet. The same-address test samples the read at the edge of the write, where the old value is due, and then again one cycle later, where the new value is due.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    // Preset word for preset entry idx: base plus idx plus one.
    function automatic logic [63:0] rfp_preset_word(input logic [63:0] base,
                                                    input int unsigned idx);
        return base + 64'(idx) + 64'd1;
    endfunction

endpackage

// File: rtl/rfp_ram.sv
// Storage array: no reset, one write port, NRD registered read ports.
module rfp_ram #(
    parameter int DEPTH = 20,
    parameter int WIDTH = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]     rd_addr,
    output logic [NRD-1:0][WIDTH-1:0]  rd_q
);

    logic [WIDTH-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < AW'(DEPTH))) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Old contents are returned on a same-address collision.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NRD; p++) begin
            rd_q[p] <= mem[rd_addr[p]];
        end
    end

endmodule

// File: rtl/rfp_flags.sv
// Written markers for the preset entries at addresses 0 .. NPRE-1.
module rfp_flags #(
    parameter int NPRE = 3,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    output logic [NPRE-1:0] seen
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else begin
            for (int i = 0; i < NPRE; i++) begin
                if (wr_en && (wr_addr == AW'(i))) begin
                    seen[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rfp_rdsel.sv
// One read port's substitution stage, aligned with the RAM read register.
module rfp_rdsel
    import rfp_pkg::*;
#(
    parameter int          NPRE        = 3,
    parameter int          AW          = 5,
    parameter int          WIDTH       = 32,
    parameter logic [63:0] PRESET_BASE = 64'hC0DE_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    input  logic [NPRE-1:0]  seen,
    input  logic [WIDTH-1:0] ram_q,
    output logic [WIDTH-1:0] rd_data
);

    logic             in_set;
    logic             flag_at;
    logic [WIDTH-1:0] pre_word;
    logic             sub_q;
    logic [WIDTH-1:0] pre_q;

    always_comb begin
        in_set   = 1'b0;
        flag_at  = 1'b0;
        pre_word = '0;
        for (int i = 0; i < NPRE; i++) begin
            if (rd_addr == AW'(i)) begin
                in_set   = 1'b1;
                flag_at  = seen[i];
                pre_word = WIDTH'(rfp_preset_word(PRESET_BASE, i));
            end
        end
    end

    // Marker sampled before this edge's write: read-before-write.
    // A read sampled during reset already sees the cleared state.
    always_ff @(posedge clk) begin
        sub_q <= in_set && (rst || !flag_at);
        pre_q <= pre_word;
    end

    assign rd_data = sub_q ? pre_q : ram_q;

endmodule

// File: rtl/rfp_regfile.sv
// Register file in a reset-less RAM with emulated reset of preset entries.
module rfp_regfile #(
    parameter int          DEPTH       = 20,
    parameter int          WIDTH       = 32,
    parameter int          NPRE        = 3,
    parameter logic [63:0] PRESET_BASE = 64'hC0DE_0000,
    localparam int         AW          = $clog2(DEPTH),
    localparam int         NRD         = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd0_addr,
    output logic [WIDTH-1:0] rd0_data,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_data
);

    logic                      wr_go;
    logic [NPRE-1:0]           seen;
    logic [NRD-1:0][AW-1:0]    rd_addr_v;
    logic [NRD-1:0][WIDTH-1:0] ram_q_v;
    logic [NRD-1:0][WIDTH-1:0] rd_data_v;

    assign wr_go        = wr_en && !rst;
    assign rd_addr_v[0] = rd0_addr;
    assign rd_addr_v[1] = rd1_addr;
    assign rd0_data     = rd_data_v[0];
    assign rd1_data     = rd_data_v[1];

    rfp_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) ram_i (
        .clk     (clk),
        .wr_en   (wr_go),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr_v),
        .rd_q    (ram_q_v)
    );

    rfp_flags #(.NPRE(NPRE), .AW(AW)) flags_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_go),
        .wr_addr (wr_addr),
        .seen    (seen)
    );

    for (genvar g = 0; g < NRD; g++) begin : g_rport
        rfp_rdsel #(
            .NPRE(NPRE), .AW(AW), .WIDTH(WIDTH), .PRESET_BASE(PRESET_BASE)
        ) sel_i (
            .clk     (clk),
            .rst     (rst),
            .rd_addr (rd_addr_v[g]),
            .seen    (seen),
            .ram_q   (ram_q_v[g]),
            .rd_data (rd_data_v[g])
        );
    end

endmodule

// File: rtl/rfp_chk.sv
module rfp_chk
    import rfp_pkg::*;
#(
    parameter int          NPRE        = 3,
    parameter int          AW          = 5,
    parameter int          WIDTH       = 32,
    parameter logic [63:0] PRESET_BASE = 64'hC0DE_0000
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [AW-1:0]    rd0_addr,
    input logic [AW-1:0]    rd1_addr,
    input logic [WIDTH-1:0] rd0_data,
    input logic [WIDTH-1:0] rd1_data,
    input logic [NPRE-1:0]  seen
);

    logic [NPRE-1:0]  wr_hot;
    logic             hit0, hit1;
    logic [WIDTH-1:0] exp0, exp1;

    always_comb begin
        wr_hot = '0;
        hit0   = 1'b0;
        hit1   = 1'b0;
        exp0   = '0;
        exp1   = '0;
        for (int i = 0; i < NPRE; i++) begin
            if (wr_addr == AW'(i)) wr_hot[i] = 1'b1;
            if (rd0_addr == AW'(i)) begin
                hit0 = !seen[i];
                exp0 = WIDTH'(rfp_preset_word(PRESET_BASE, i));
            end
            if (rd1_addr == AW'(i)) begin
                hit1 = !seen[i];
                exp1 = WIDTH'(rfp_preset_word(PRESET_BASE, i));
            end
        end
    end

    // R5: leaving reset, no marker is set
    p_reset_clears_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (seen == '0));

    // R4: a write to a preset entry sets its marker
    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_hot != '0)) |=> ((seen & $past(wr_hot)) != '0));

    // R4: markers never drop without reset
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((seen & $past(seen)) == $past(seen)));

    // R3: unwritten preset entry on port 0 shows its preset value
    p_sub_port0_r3: assert property (@(posedge clk) disable iff (rst)
        hit0 |=> (rd0_data == $past(exp0)));

    // R9: same on port 1
    p_sub_port1_r9: assert property (@(posedge clk) disable iff (rst)
        hit1 |=> (rd1_data == $past(exp1)));

endmodule

bind rfp_regfile rfp_chk #(
    .NPRE(NPRE), .AW(AW), .WIDTH(WIDTH), .PRESET_BASE(PRESET_BASE)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd0_addr (rd0_addr),
    .rd1_addr (rd1_addr),
    .rd0_data (rd0_data),
    .rd1_data (rd1_data),
    .seen     (seen)
);

// File: tb/rfp_regfile_tb_top.sv
`timescale 1ns/1ps
module rfp_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd0_addr = '0;
    logic [4:0]  rd1_addr = '0;
    logic [31:0] rd0_data, rd1_data;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rfp_regfile dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data)
    );

    function automatic logic [31:0] preset(input int i);
        return 32'hC0DE_0001 + 32'(i);
    endfunction

    task automatic chk(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read2(input logic [4:0] a0, input logic [4:0] a1,
                         output logic [31:0] q0, output logic [31:0] q1);
        rd0_addr = a0; rd1_addr = a1;
        @(negedge clk);
        q0 = rd0_data; q1 = rd1_data;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_values();
        logic [31:0] q0, q1;
        do_reset();
        read2(5'd0, 5'd1, q0, q1);
        chk("R3 addr0 preset", q0, preset(0));
        chk("R9 port1 addr1 preset", q1, preset(1));
        read2(5'd2, 5'd0, q0, q1);
        chk("R3 addr2 preset", q0, preset(2));
        chk("R9 port1 addr0 preset", q1, preset(0));
    endtask

    task automatic t_write_read();
        logic [31:0] q0, q1;
        do_write(5'd1, 32'h1111_2222);
        read2(5'd1, 5'd0, q0, q1);
        chk("R4 addr1 written", q0, 32'h1111_2222);
        chk("R9 port1 addr0 still preset", q1, preset(0));
        do_write(5'd5, 32'hDEAD_0005);
        do_write(5'd19, 32'h0BAD_0019);
        read2(5'd19, 5'd5, q0, q1);
        chk("R1 addr19", q0, 32'h0BAD_0019);
        chk("R1 addr5 port1", q1, 32'hDEAD_0005);
        do_write(5'd0, 32'hAAAA_0000);
        read2(5'd0, 5'd1, q0, q1);
        chk("R4 addr0 written", q0, 32'hAAAA_0000);
        chk("R4 addr1 kept", q1, 32'h1111_2222);
    endtask

    task automatic t_latency();
        logic [31:0] q0, q1;
        read2(5'd5, 5'd5, q0, q1);
        chk("R2 addr5 settled", q0, 32'hDEAD_0005);
        rd0_addr = 5'd19;
        #1;
        chk("R2 output holds before edge", rd0_data, 32'hDEAD_0005);
        @(negedge clk);
        chk("R2 output after one edge", rd0_data, 32'h0BAD_0019);
    endtask

    task automatic t_second_reset();
        logic [31:0] q0, q1;
        // address sampled during reset must already show preset
        rd0_addr = 5'd0;
        rst = 1'b1;
        @(negedge clk);
        chk("R5 read sampled in reset", rd0_data, preset(0));
        @(negedge clk);
        rst = 1'b0;
        read2(5'd1, 5'd2, q0, q1);
        chk("R5 addr1 preset again", q0, preset(1));
        chk("R5 addr2 preset again", q1, preset(2));
        read2(5'd5, 5'd19, q0, q1);
        chk("R6 addr5 kept", q0, 32'hDEAD_0005);
        chk("R6 addr19 kept", q1, 32'h0BAD_0019);
    endtask

    task automatic t_write_in_reset();
        logic [31:0] q0, q1;
        rst = 1'b1;
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'h5555_5555;
        @(negedge clk);
        wr_addr = 5'd5; wr_data = 32'h5A5A_5A5A;
        @(negedge clk);
        wr_en = 1'b0;
        rst = 1'b0;
        read2(5'd0, 5'd5, q0, q1);
        chk("R8 addr0 not marked", q0, preset(0));
        chk("R8 addr5 not stored", q1, 32'hDEAD_0005);
    endtask

    task automatic t_same_cycle();
        logic [31:0] q0, q1;
        // unwritten preset entry collides with a write
        rd0_addr = 5'd2; rd1_addr = 5'd2;
        do_write(5'd2, 32'h0000_0022);
        chk("R7 preset old value", rd0_data, preset(2));
        chk("R7 port1 preset old value", rd1_data, preset(2));
        read2(5'd2, 5'd2, q0, q1);
        chk("R7 new value next read", q0, 32'h0000_0022);
        // plain entry collides with a write
        rd0_addr = 5'd5;
        do_write(5'd5, 32'h5555_0000);
        chk("R7 plain old value", rd0_data, 32'hDEAD_0005);
        read2(5'd5, 5'd2, q0, q1);
        chk("R7 plain new value", q0, 32'h5555_0000);
    endtask

    initial begin
        @(negedge clk);
        t_reset_values();
        t_write_read();
        t_latency();
        t_second_reset();
        t_write_in_reset();
        t_same_cycle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule